// File: doc/BRIEF.md
# Storage-Adapter Control and Status Register Bank

This block is the host-visible register bank of a mass-storage bus adapter. It holds seven 16-bit registers, selected by a 3-bit index: a primary control word (command code, start bit, interrupt enable, completion flag, two address-extension bits and two summary status bits), a word counter, a bus address, a secondary control word (drive unit, address-hold, test bits, error flags and an adapter-wide clear), a data buffer, a 6-bit address extension and a tertiary control word (write-check error flags, interrupt-enable copy, parity-test pattern). Writes carry two byte enables, so either half of a word may be written alone.

A write often reaches beyond its own register. Setting the error-clear bit wipes the error flags in two other registers. A start request for a data-transfer command made while the previous operation is still busy is refused and logged as a program error. The adapter clear bit resets the whole bank. The address-extension and interrupt-enable fields appear in two registers each, and a write to either copy is seen in both. The two summary bits are derived from the error flags. The transfer engine reports completion and errors through single-cycle input strobes. An accepted start request is passed to the drive side as a one-cycle pulse with its command code.

Top module: `adp_csr_bank`

Register indices: 0 primary control, 1 word counter, 2 bus address, 3 secondary control, 4 data buffer, 5 address extension, 6 tertiary control, 7 unassigned. Read data is combinational from the current state. A write takes effect at the rising clock edge in which `acc_en` and `acc_wr` are high.

## Requirements
- R1: After reset, index 0 reads 16'h0080 (completion flag, bit 7, set), index 3 reads 16'h00C0 and every other defined index reads 0. `go_pulse` is low.
- R2: An access with index 7 drives `acc_err` high and `acc_rdata` to 0 in the same cycle. A write to index 7 changes no register.
- R3: Writes to indices 1 and 4 replace the low byte when `acc_be[0]` is set and the high byte when `acc_be[1]` is set. A byte that is not enabled keeps its value.
- R4: Index 2 follows R3, but bit 0 always reads 0.
- R5: A low-byte write to index 0 with bit 0 (start) set and a command code in bits 5:1 of 20 or more is a transfer start. If the completion flag is set, `go_pulse` is high for one cycle after the write and `go_func` holds the code. The completion flag then reads 0, and the secondary error byte and the tertiary error bits are cleared.
- R6: A transfer start made while the completion flag is clear raises no pulse. It sets the program-error flag (index 3, bit 10), which forces bits 15 and 14 of index 0 to read 1.
- R7: A start with a command code below 20 always pulses `go_pulse` with its code and leaves the completion flag unchanged.
- R8: A high-byte write to index 0 with bit 14 set clears index 3 bits 15:8, index 6 bits 12:11 and the sticky diagnostic flag of R12.
- R9: A high-byte write to index 0 loads bits 9:8 only while the completion flag is set. Those two bits are the same storage as index 5 bits 1:0. A low-byte write to index 5 loads all six bits, and a write with only the high byte enabled is ignored. Index 5 bits 15:6 read 0.
- R10: Index 3 always reads bits 7:6 as 1 and bit 5 as 0. A low-byte write with bit 5 set returns the whole bank to the R1 state. Otherwise the low byte loads bits 4:0, and the high byte loads test bits 9 and 13.
- R11: Index 0 bit 14 reads 1 exactly when any index 3 bit 15:8 is set. Bit 15 reads 1 when bit 14 does or the diagnostic flag is set. Bits of `err_set` are ORed into index 3 bits 15:8 and stay set.
- R12: A write that takes index 3 bit 9 or bit 13 from 0 to 1 sets a sticky diagnostic flag. Index 0 bit 15 stays 1 after the test bit is written back to 0.
- R13: Interrupt enable is a single bit, seen at bit 6 of both index 0 and index 6, and a low-byte write to either register loads it. A low-byte write to index 6 also loads bits 3:0. A write to index 6 with only the high byte enabled is ignored.
- R14: `done_set` sets the completion flag. `wchk_set[1]` sets index 6 bit 12 and `wchk_set[0]` sets bit 11. These bits do not affect index 0 bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access in this cycle |
| acc_wr | input | 1 | Access is a write |
| acc_idx | input | 3 | Register index |
| acc_be | input | 2 | Byte enables, bit 0 = low byte |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data for `acc_idx` |
| acc_err | output | 1 | Access to an unassigned index |
| done_set | input | 1 | Transfer engine: operation finished |
| err_set | input | 8 | Transfer engine: error flags for index 3 bits 15:8 |
| wchk_set | input | 2 | Transfer engine: write-check odd/even miscompare |
| go_pulse | output | 1 | Accepted start request, one cycle |
| go_func | output | 5 | Command code of the last accepted start |

## Verification
All state is visible through the read path in the same cycle. A wrong completion flag or error byte therefore shows at the next read of index 0 or 3, through the derived summary bits as well as the raw fields. A wrong busy test shows one cycle after the start write, as a pulse that should not be there or one that is missing. A mirrored field that has split into two copies shows when it is read through the register that was not written. The bench keeps a model of every field and reads after each directed and random write, so a fault becomes visible within one access of the write that caused it.

// File: rtl/adp_csr_pkg.sv
`timescale 1ns/1ps
package adp_csr_pkg;
    localparam int DATA_W   = 16;
    localparam int IDX_W    = 3;
    localparam int FUNC_W   = 5;
    localparam int EXT_W    = 6;
    localparam int ERR_W    = 8;
    localparam int UNIT_W   = 5;
    localparam int PAT_W    = 4;
    localparam int WCHK_W   = 2;
    localparam int XFER_MIN = 20;

    // error byte positions (bit k of the byte is word bit 8+k)
    localparam int E_MXF = 1;
    localparam int E_PGE = 2;
    localparam int E_PAR = 5;

    typedef enum logic [IDX_W-1:0] {
        RG_CTL1 = 3'd0,
        RG_WCNT = 3'd1,
        RG_BADR = 3'd2,
        RG_CTL2 = 3'd3,
        RG_DBUF = 3'd4,
        RG_BEXT = 3'd5,
        RG_CTL3 = 3'd6,
        RG_NONE = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/adp_lane_merge.sv
`timescale 1ns/1ps
module adp_lane_merge #(
    parameter int W = 16
) (
    input  logic [W-1:0]     cur,
    input  logic [W-1:0]     wdata,
    input  logic [W/8-1:0]   be,
    output logic [W-1:0]     merged
);
    localparam int LANES = W / 8;
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = be[g] ? wdata[g*8 +: 8] : cur[g*8 +: 8];
    end
endmodule

// File: rtl/adp_go_decode.sv
`timescale 1ns/1ps
module adp_go_decode #(
    parameter int FUNC_W   = 5,
    parameter int XFER_MIN = 20
) (
    input  logic              ctl_lo_wr,
    input  logic [FUNC_W:0]   cmd,
    input  logic              done,
    output logic              go_req,
    output logic              xfer_start,
    output logic              pgm_err
);
    logic is_xfer;
    assign go_req     = ctl_lo_wr && cmd[0];
    assign is_xfer    = (int'(cmd[FUNC_W:1]) >= XFER_MIN);
    assign pgm_err    = go_req && is_xfer && !done;
    assign xfer_start = go_req && is_xfer && done;
endmodule

// File: rtl/adp_status_sum.sv
`timescale 1ns/1ps
module adp_status_sum #(
    parameter int ERR_W = 8
) (
    input  logic [ERR_W-1:0] err,
    input  logic             diag,
    output logic             tre,
    output logic             sc
);
    assign tre = |err;
    assign sc  = tre || diag;
endmodule

// File: rtl/adp_csr_bank.sv
`timescale 1ns/1ps
module adp_csr_bank
    import adp_csr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_en,
    input  logic                acc_wr,
    input  logic [IW-1:0]       acc_idx,
    input  logic [DW/8-1:0]     acc_be,
    input  logic [DW-1:0]       acc_wdata,
    output logic [DW-1:0]       acc_rdata,
    output logic                acc_err,
    input  logic                done_set,
    input  logic [ERR_W-1:0]    err_set,
    input  logic [WCHK_W-1:0]   wchk_set,
    output logic                go_pulse,
    output logic [FUNC_W-1:0]   go_func
);
    localparam int LANES = DW / 8;

    reg_idx_e idx;
    assign idx = reg_idx_e'(acc_idx);

    // state
    logic [DW-1:0]     wc_q, ba_q, db_q;
    logic [EXT_W-1:0]  bext_q;
    logic              done_q, ie_q, diag_q;
    logic [UNIT_W-1:0] lo2_q;
    logic [ERR_W-1:0]  err_q;
    logic [WCHK_W-1:0] wchk_q;
    logic [PAT_W-1:0]  pat_q;
    logic              go_pulse_q;
    logic [FUNC_W-1:0] go_func_q;

    // write strobes
    logic wr, wr_ctl1_lo, wr_ctl1_hi, wr_ctl2_lo, wr_ctl2_hi, wr_ext_lo, wr_ctl3_lo;
    logic tre_clr, ctl_clear, diag_rise;
    assign wr         = acc_en && acc_wr;
    assign wr_ctl1_lo = wr && (idx == RG_CTL1) && acc_be[0];
    assign wr_ctl1_hi = wr && (idx == RG_CTL1) && acc_be[1];
    assign wr_ctl2_lo = wr && (idx == RG_CTL2) && acc_be[0];
    assign wr_ctl2_hi = wr && (idx == RG_CTL2) && acc_be[1];
    assign wr_ext_lo  = wr && (idx == RG_BEXT) && acc_be[0];
    assign wr_ctl3_lo = wr && (idx == RG_CTL3) && acc_be[0];
    assign tre_clr    = wr_ctl1_hi && acc_wdata[14];
    assign ctl_clear  = wr_ctl2_lo && acc_wdata[5];
    assign diag_rise  = wr_ctl2_hi &&
                        ((acc_wdata[8+E_MXF] && !err_q[E_MXF]) ||
                         (acc_wdata[8+E_PAR] && !err_q[E_PAR]));

    // start decode
    logic go_req, xfer_start, pgm_err;
    adp_go_decode #(.FUNC_W(FUNC_W), .XFER_MIN(XFER_MIN)) u_go (
        .ctl_lo_wr (wr_ctl1_lo),
        .cmd       (acc_wdata[FUNC_W:0]),
        .done      (done_q),
        .go_req    (go_req),
        .xfer_start(xfer_start),
        .pgm_err   (pgm_err)
    );

    // byte-lane data registers
    logic [DW-1:0] wc_m, ba_m, db_m;
    adp_lane_merge #(.W(DW)) u_mwc (.cur(wc_q), .wdata(acc_wdata), .be(acc_be), .merged(wc_m));
    adp_lane_merge #(.W(DW)) u_mba (.cur(ba_q), .wdata(acc_wdata), .be(acc_be), .merged(ba_m));
    adp_lane_merge #(.W(DW)) u_mdb (.cur(db_q), .wdata(acc_wdata), .be(acc_be), .merged(db_m));

    // summary bits
    logic tre, sc;
    adp_status_sum #(.ERR_W(ERR_W)) u_sum (.err(err_q), .diag(diag_q), .tre(tre), .sc(sc));

    // next state
    logic [ERR_W-1:0]  err_n;
    logic [WCHK_W-1:0] wchk_n;
    logic [EXT_W-1:0]  bext_n;
    logic              done_n, diag_n, ie_n;
    always_comb begin
        err_n = err_q;
        if (tre_clr || xfer_start) err_n = '0;
        if (pgm_err) err_n[E_PGE] = 1'b1;
        if (wr_ctl2_hi) begin
            err_n[E_MXF] = acc_wdata[8+E_MXF];
            err_n[E_PAR] = acc_wdata[8+E_PAR];
        end
        err_n = err_n | err_set;

        wchk_n = wchk_q;
        if (tre_clr || xfer_start) wchk_n = '0;
        wchk_n = wchk_n | wchk_set;

        done_n = done_q;
        if (xfer_start) done_n = 1'b0;
        if (done_set)   done_n = 1'b1;

        diag_n = diag_q;
        if (tre_clr)   diag_n = 1'b0;
        if (diag_rise) diag_n = 1'b1;

        bext_n = bext_q;
        if (wr_ctl1_hi && done_q) bext_n[1:0] = acc_wdata[9:8];
        if (wr_ext_lo)            bext_n      = acc_wdata[EXT_W-1:0];

        ie_n = ie_q;
        if (wr_ctl1_lo || wr_ctl3_lo) ie_n = acc_wdata[6];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wc_q <= '0; ba_q <= '0; db_q <= '0; bext_q <= '0;
            done_q <= 1'b1; ie_q <= 1'b0; diag_q <= 1'b0;
            lo2_q <= '0; err_q <= '0; wchk_q <= '0; pat_q <= '0;
            go_pulse_q <= 1'b0; go_func_q <= '0;
        end else if (ctl_clear) begin
            wc_q <= '0; ba_q <= '0; db_q <= '0; bext_q <= '0;
            done_q <= 1'b1; ie_q <= 1'b0; diag_q <= 1'b0;
            lo2_q <= '0; err_q <= '0; wchk_q <= '0; pat_q <= '0;
            go_pulse_q <= 1'b0; go_func_q <= '0;
        end else begin
            if (wr && idx == RG_WCNT) wc_q <= wc_m;
            if (wr && idx == RG_BADR) ba_q <= {ba_m[DW-1:1], 1'b0};
            if (wr && idx == RG_DBUF) db_q <= db_m;
            if (wr_ctl2_lo) lo2_q <= acc_wdata[UNIT_W-1:0];
            if (wr_ctl3_lo) pat_q <= acc_wdata[PAT_W-1:0];
            bext_q <= bext_n;
            done_q <= done_n;
            ie_q   <= ie_n;
            diag_q <= diag_n;
            err_q  <= err_n;
            wchk_q <= wchk_n;
            go_pulse_q <= go_req && !pgm_err;
            if (go_req && !pgm_err) go_func_q <= acc_wdata[FUNC_W:1];
        end
    end

    assign go_pulse = go_pulse_q;
    assign go_func  = go_func_q;

    // read path
    always_comb begin
        acc_rdata = '0;
        acc_err   = 1'b0;
        unique case (idx)
            RG_CTL1: acc_rdata = {sc, tre, 4'b0, bext_q[1:0], done_q, ie_q, 6'b0};
            RG_WCNT: acc_rdata = wc_q;
            RG_BADR: acc_rdata = ba_q;
            RG_CTL2: acc_rdata = {err_q, 2'b11, 1'b0, lo2_q};
            RG_DBUF: acc_rdata = db_q;
            RG_BEXT: acc_rdata = {{(DW-EXT_W){1'b0}}, bext_q};
            RG_CTL3: acc_rdata = {3'b0, wchk_q, 4'b0, ie_q, 2'b0, pat_q};
            RG_NONE: acc_err   = acc_en;
        endcase
    end
endmodule

// File: rtl/adp_csr_bank_chk.sv
`timescale 1ns/1ps
module adp_csr_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_en,
    input logic        acc_wr,
    input logic [2:0]  acc_idx,
    input logic [1:0]  acc_be,
    input logic [15:0] acc_wdata,
    input logic [15:0] acc_rdata,
    input logic        acc_err,
    input logic        done_set,
    input logic        go_pulse,
    input logic        done_q,
    input logic [7:0]  err_q,
    input logic [5:0]  bext_q
);
    logic xfer_wr;
    assign xfer_wr = acc_en && acc_wr && acc_idx == 3'd0 && acc_be[0] &&
                     acc_wdata[0] && (acc_wdata[5:1] >= 5'd20);

    // R2
    bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_idx == 3'd7) |-> (acc_err && acc_rdata == 16'h0));
    // R4
    ba_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_idx == 3'd2) |-> !acc_rdata[0]);
    // R10
    ctl2_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_idx == 3'd3) |-> (acc_rdata[7:6] == 2'b11 && !acc_rdata[5]));
    // R9
    ext_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_idx == 3'd5) |-> (acc_rdata[15:6] == 10'h0));
    // R11
    tre_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_idx == 3'd0 && (|err_q)) |-> (acc_rdata[15:14] == 2'b11));
    // R6
    pgm_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_wr && !done_q) |=> (!go_pulse && err_q[2]));
    // R5
    xfer_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_wr && done_q && !done_set) |=> (go_pulse && !done_q));
    // R9
    uae_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_idx == 3'd0 && acc_be[1] && !done_q)
        |=> $stable(bext_q[1:0]));
endmodule

bind adp_csr_bank adp_csr_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_idx(acc_idx), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_err(acc_err), .done_set(done_set),
    .go_pulse(go_pulse), .done_q(done_q), .err_q(err_q), .bext_q(bext_q)
);

// File: tb/adp_csr_bank_test.sv
`timescale 1ns/1ps
module adp_csr_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0;
    logic [2:0]  acc_idx = '0;
    logic [1:0]  acc_be = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        acc_err;
    logic        done_set = 1'b0;
    logic [7:0]  err_set = '0;
    logic [1:0]  wchk_set = '0;
    logic        go_pulse;
    logic [4:0]  go_func;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    adp_csr_bank uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_idx(acc_idx), .acc_be(acc_be), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err), .done_set(done_set),
        .err_set(err_set), .wchk_set(wchk_set), .go_pulse(go_pulse),
        .go_func(go_func)
    );

    // reference state, built from the requirements
    logic [15:0] m_wc, m_ba, m_db;
    logic [5:0]  m_ext;
    logic        m_done, m_ie, m_diag, m_gp;
    logic [4:0]  m_lo, m_gf;
    logic [7:0]  m_err;
    logic [1:0]  m_wchk;
    logic [3:0]  m_pat;

    task automatic m_reset();
        m_wc = 0; m_ba = 0; m_db = 0; m_ext = 0; m_done = 1; m_ie = 0;
        m_diag = 0; m_lo = 0; m_err = 0; m_wchk = 0; m_pat = 0; m_gp = 0;
    endtask

    function automatic logic [15:0] lanes(logic [15:0] c, logic [15:0] d, logic [1:0] be);
        return {be[1] ? d[15:8] : c[15:8], be[0] ? d[7:0] : c[7:0]};
    endfunction

    function automatic logic [15:0] exp_rd(int idx);
        logic tre, sc;
        tre = |m_err;
        sc  = tre | m_diag;
        case (idx)
            0: return {sc, tre, 4'b0, m_ext[1:0], m_done, m_ie, 6'b0};
            1: return m_wc;
            2: return m_ba;
            3: return {m_err, 2'b11, 1'b0, m_lo};
            4: return m_db;
            5: return {10'b0, m_ext};
            6: return {3'b0, m_wchk, 4'b0, m_ie, 2'b0, m_pat};
            default: return 16'h0;
        endcase
    endfunction

    task automatic m_write(int idx, logic [1:0] be, logic [15:0] d);
        logic xf;
        m_gp = 0;
        case (idx)
            0: begin
                if (be[1] && d[14]) begin m_err = 0; m_wchk = 0; m_diag = 0; end
                if (be[1] && m_done) m_ext[1:0] = d[9:8];
                if (be[0]) begin
                    m_ie = d[6];
                    if (d[0]) begin
                        xf = (d[5:1] >= 5'd20);
                        if (xf && !m_done) m_err[2] = 1;
                        else begin
                            m_gp = 1; m_gf = d[5:1];
                            if (xf) begin m_done = 0; m_err = 0; m_wchk = 0; end
                        end
                    end
                end
            end
            1: m_wc = lanes(m_wc, d, be);
            2: begin m_ba = lanes(m_ba, d, be); m_ba[0] = 0; end
            3: begin
                if (be[0] && d[5]) m_reset();
                else begin
                    if (be[0]) m_lo = d[4:0];
                    if (be[1]) begin
                        if ((d[9] && !m_err[1]) || (d[13] && !m_err[5])) m_diag = 1;
                        m_err[1] = d[9]; m_err[5] = d[13];
                    end
                end
            end
            4: m_db = lanes(m_db, d, be);
            5: if (be[0]) m_ext = d[5:0];
            6: if (be[0]) begin m_ie = d[6]; m_pat = d[3:0]; end
            default: ;
        endcase
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(int idx, logic [1:0] be, logic [15:0] d);
        m_write(idx, be, d);
        @(negedge clk);
        acc_en = 1; acc_wr = 1; acc_idx = idx[2:0]; acc_be = be; acc_wdata = d;
        @(posedge clk); #1;
        acc_en = 0; acc_wr = 0;
    endtask

    task automatic rd_chk(int idx, string tag);
        @(negedge clk);
        acc_en = 1; acc_wr = 0; acc_idx = idx[2:0];
        #1;
        chk(tag, {16'h0, acc_rdata}, {16'h0, exp_rd(idx)});
        acc_en = 0;
    endtask

    task automatic go_chk(string tag);
        chk(tag, {26'h0, go_pulse, go_func & {5{m_gp}}}, {26'h0, m_gp, m_gf & {5{m_gp}}});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd1357);
        m_reset(); m_gf = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        for (int i = 0; i < 7; i++) rd_chk(i, "R1 reset read");
        chk("R1 go idle", {31'h0, go_pulse}, 32'h0);

        // R2 unassigned index
        @(negedge clk); acc_en = 1; acc_idx = 3'd7; #1;
        chk("R2 err flag", {31'h0, acc_err}, 32'h1);
        chk("R2 zero data", {16'h0, acc_rdata}, 32'h0);
        acc_en = 0;
        bus_wr(7, 2'b11, 16'hFFFF);
        for (int i = 0; i < 7; i++) rd_chk(i, "R2 write ignored");

        // R3 byte lanes
        bus_wr(1, 2'b11, 16'h1234); bus_wr(1, 2'b01, 16'hAACD); rd_chk(1, "R3 low byte");
        bus_wr(4, 2'b10, 16'h5AEE); rd_chk(4, "R3 high byte");
        // R4
        bus_wr(2, 2'b11, 16'h7777); rd_chk(2, "R4 lsb zero");

        // R9 extension and mirror
        bus_wr(5, 2'b11, 16'hFFFF); rd_chk(5, "R9 ext upper zero"); rd_chk(0, "R9 mirror to ctl1");
        bus_wr(5, 2'b10, 16'h0000); rd_chk(5, "R9 high-only ignored");
        bus_wr(0, 2'b10, 16'h0100); rd_chk(5, "R9 ctl1 to ext");

        // R5 transfer start
        bus_wr(0, 2'b01, 16'h0029); go_chk("R5 go pulse");
        rd_chk(0, "R5 done cleared");
        bus_wr(0, 2'b10, 16'h0300); rd_chk(5, "R9 locked while busy");

        // R6 start while busy
        bus_wr(0, 2'b01, 16'h003F); go_chk("R6 no pulse");
        rd_chk(3, "R6 program error"); rd_chk(0, "R6 summary bits");

        // R7 non-transfer start
        bus_wr(0, 2'b01, 16'h0027); go_chk("R7 pulse"); rd_chk(0, "R7 done kept");

        // R14 engine strobes
        @(negedge clk); done_set = 1; wchk_set = 2'b11;
        @(posedge clk); #1 done_set = 0; wchk_set = 0;
        m_done = 1; m_wchk = 2'b11;
        rd_chk(0, "R14 done set"); rd_chk(6, "R14 write check bits");

        // R8 error clear
        bus_wr(0, 2'b10, 16'h4000);
        rd_chk(3, "R8 ctl2 errors cleared"); rd_chk(6, "R8 ctl3 errors cleared");
        rd_chk(0, "R8 summary cleared");

        // R11 external errors
        @(negedge clk); err_set = 8'h08; @(posedge clk); #1 err_set = 0; m_err[3] = 1;
        rd_chk(0, "R11 forced summary"); rd_chk(3, "R11 sticky flag");
        bus_wr(0, 2'b10, 16'h4000);

        // R12 diagnostic flag
        bus_wr(3, 2'b10, 16'h2000); rd_chk(0, "R12 diag set");
        bus_wr(3, 2'b10, 16'h0000); rd_chk(0, "R12 diag sticky");
        rd_chk(3, "R12 test bit cleared");

        // R13 shared enable
        bus_wr(0, 2'b01, 16'h0040); rd_chk(6, "R13 enable mirrored");
        bus_wr(6, 2'b10, 16'h0000); rd_chk(0, "R13 high-only ignored");
        bus_wr(6, 2'b01, 16'h000A); rd_chk(0, "R13 ctl3 to ctl1"); rd_chk(6, "R13 pattern");

        // R10 adapter clear
        bus_wr(3, 2'b01, 16'h0017); rd_chk(3, "R10 unit field");
        bus_wr(3, 2'b01, 16'h0020);
        for (int i = 0; i < 7; i++) rd_chk(i, "R10 clear state");

        // random mix over data registers
        for (int n = 0; n < 400; n++) begin
            int pick, idx;
            pick = int'($urandom % 5);
            idx = (pick == 0) ? 1 : (pick == 1) ? 2 : (pick == 2) ? 4 : (pick == 3) ? 5 : 6;
            if ($urandom % 2 == 0)
                bus_wr(idx, 2'($urandom % 4), 16'($urandom));
            else
                rd_chk(idx, (idx == 2) ? "R4 random" : (idx == 5) ? "R9 random" :
                            (idx == 6) ? "R13 random" : "R3 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule